// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures the rate of a fast clock by counting its cycles over a window set by a slow reference clock whose rate is known. The measured clock is the main clock source selected elsewhere on the chip. It may be an internal RC oscillator or an external clock input, and the meter treats both the same way. The reference clock enters the measured-clock domain as data. There it goes through a two-flop synchronizer, and its rising and falling edges are detected in that domain. The count runs and is held in that domain. A ready indication is then carried back to the reading domain, and the result is presented there.

When the read-side enable is set, the enable is synchronized into the measured domain and the meter state machine leaves `ST_IDLE` for `ST_ARM`. It waits in `ST_ARM` for the next reference rising edge, then moves to `ST_COUNT`. In `ST_COUNT` a 16-bit saturating counter advances on every measured-clock cycle while a 4-bit counter tracks reference falling edges. On the 16th falling edge the machine enters `ST_DONE`, and the count freezes there. Named transitions: `ARM_ON_ENABLE` (`ST_IDLE` to `ST_ARM`), `OPEN_ON_RISE` (`ST_ARM` to `ST_COUNT`), `CLOSE_ON_FALL16` (`ST_COUNT` to `ST_DONE`), and `DROP_ON_DISABLE` (any state to `ST_IDLE` when the enable clears).

The window lasts from a reference rising edge to the 16th falling edge after it, which is 15.5 reference periods. With a reference half period of H measured-clock cycles, the result is 31·H. Software reads `ready_o` and samples `count_o` only after it has seen ready set.

Top module: `clk_freq_meter`

## Requirements
- R1: After `meas_en` is set, nothing is counted until a reference rising edge arrives. While `ref_clk` stays static, `ready_o` stays 0 and `count_o` stays 0.
- R2: While the window is open, the count advances by exactly one per `mclk` cycle. The result equals the number of `mclk` cycles from the opening rising edge to the closing falling edge: 31·H, where H is the reference half period in `mclk` cycles.
- R3: The window closes at the 16th reference falling edge after the opening rising edge, and `ready_o` then rises.
- R4: Once the window has closed, `count_o` and `ready_o` stay constant for as long as `meas_en` stays set, whatever further reference edges arrive.
- R5: The rule in R2 holds for any ratio of measured clock to reference clock, so a faster or slower source gives a proportionally larger or smaller result.
- R6: The count saturates at 0xFFFF and never wraps.
- R7: Clearing `meas_en` abandons any measurement in progress. Within two `rd_clk` cycles it drives both `ready_o` and `count_o` to 0.
- R8: Setting `meas_en` again starts a fresh measurement. The new result reflects only the new window.
- R9: `count_o` is 0 whenever `ready_o` is 0, and the frozen result appears in the same `rd_clk` cycle in which `ready_o` rises. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Reading-domain clock |
| rd_rst_n | input | 1 | Reading-domain active-low reset |
| meas_en | input | 1 | Measurement enable, in the reading domain |
| count_o | output | 16 | Frozen cycle count, 0 until ready |
| ready_o | output | 1 | Result valid, in the reading domain |
| mclk | input | 1 | Measured main clock |
| mclk_rst_n | input | 1 | Measured-domain active-low reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to both domains |

## Verification
A wrong internal state shows at the ports only after the window closes. A counter that skips or repeats cycles gives a result other than 31·H. A fall counter that closes early or late gives a result off by a multiple of 2·H, and a wrapping counter gives a small value where 0xFFFF is expected. Those faults become visible within a few reading cycles of `ready_o` rising. A state machine stuck in its counting state shows as a count that keeps moving after ready. Stale state carried across a disable shows within two reading cycles as a nonzero `count_o` or a high `ready_o` after `meas_en` drops. The bench therefore compares `count_o` against the expected result in every reading cycle while ready is set, and against 0 otherwise.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } meter_state_t;

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cfm_ref_edge.sv
module cfm_ref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic rise,
    output logic fall
);
    logic ref_s;
    logic ref_prev_q;

    cfm_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ref_async),
        .q     (ref_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_prev_q <= 1'b0;
        end else begin
            ref_prev_q <= ref_s;
        end
    end

    assign rise = ref_s & ~ref_prev_q;
    assign fall = ~ref_s & ref_prev_q;
endmodule

// File: rtl/cfm_core.sv
module cfm_core
    import cfm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WIN_FALLS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output meter_state_t     state
);
    localparam int FALL_W = (WIN_FALLS > 1) ? $clog2(WIN_FALLS) : 1;
    localparam logic [FALL_W-1:0] LAST_FALL = FALL_W'(WIN_FALLS - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    meter_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [FALL_W-1:0] falls_q;
    logic              done_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_ARM;
            ST_ARM:   if (!en) state_d = ST_IDLE;
                      else if (rise) state_d = ST_COUNT;
            ST_COUNT: if (!en) state_d = ST_IDLE;
                      else if (fall && falls_q == LAST_FALL) state_d = ST_DONE;
            ST_DONE:  if (!en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: counters and registered done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            falls_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_d == ST_DONE);
            unique case (state_q)
                ST_COUNT: begin
                    if (!en) begin
                        cnt_q   <= '0;
                        falls_q <= '0;
                    end else begin
                        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                        if (fall) falls_q <= falls_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!en) begin
                        cnt_q   <= '0;
                        falls_q <= '0;
                    end
                end
                default: begin
                    cnt_q   <= '0;
                    falls_q <= '0;
                end
            endcase
        end
    end

    assign cnt   = cnt_q;
    assign done  = done_q;
    assign state = state_q;
endmodule

// File: rtl/cfm_read.sv
module cfm_read #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             done_async,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] count_o,
    output logic             ready_o
);
    logic             done_s;
    logic             ready_q;
    logic [CNT_W-1:0] count_q;

    cfm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (done_async),
        .q     (done_s)
    );

    // count_in is frozen long before done_s rises, so it is safe to capture here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            count_q <= '0;
        end else begin
            ready_q <= en & done_s;
            if (en && done_s) begin
                if (!ready_q) count_q <= count_in;
            end else begin
                count_q <= '0;
            end
        end
    end

    assign count_o = count_q;
    assign ready_o = ready_q;
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
    import cfm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int WIN_FALLS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             meas_en,
    output logic [CNT_W-1:0] count_o,
    output logic             ready_o,
    input  logic             mclk,
    input  logic             mclk_rst_n,
    input  logic             ref_clk
);
    logic             en_m;
    logic             ref_rise;
    logic             ref_fall;
    logic [CNT_W-1:0] core_cnt;
    logic             core_done;
    meter_state_t     core_state;

    cfm_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk   (mclk),
        .rst_n (mclk_rst_n),
        .d     (meas_en),
        .q     (en_m)
    );

    cfm_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (mclk),
        .rst_n     (mclk_rst_n),
        .ref_async (ref_clk),
        .rise      (ref_rise),
        .fall      (ref_fall)
    );

    cfm_core #(.CNT_W(CNT_W), .WIN_FALLS(WIN_FALLS)) u_core (
        .clk   (mclk),
        .rst_n (mclk_rst_n),
        .en    (en_m),
        .rise  (ref_rise),
        .fall  (ref_fall),
        .cnt   (core_cnt),
        .done  (core_done),
        .state (core_state)
    );

    cfm_read #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_read (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .en         (meas_en),
        .done_async (core_done),
        .count_in   (core_cnt),
        .count_o    (count_o),
        .ready_o    (ready_o)
    );
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker
    import cfm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             mclk,
    input logic             mclk_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             meas_en,
    input meter_state_t     state,
    input logic [CNT_W-1:0] cnt,
    input logic             done,
    input logic             ref_fall,
    input logic [CNT_W-1:0] count_o,
    input logic             ready_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_arm_holds_zero_r1: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
        (state == ST_ARM) |-> (cnt == '0));

    p_close_on_fall_r3: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
        $rose(done) |-> $past(ref_fall));

    p_frozen_r4: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
        (done && $past(done)) |-> $stable(cnt));

    p_no_wrap_r6: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0));

    p_ready_needs_en_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ready_o |-> $past(meas_en));

    p_clear_on_disable_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !meas_en |=> (count_o == '0 && !ready_o));

    p_count_gated_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !ready_o |-> (count_o == '0));
endmodule

bind clk_freq_meter cfm_checker #(.CNT_W(CNT_W)) u_chk (
    .mclk       (mclk),
    .mclk_rst_n (mclk_rst_n),
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .meas_en    (meas_en),
    .state      (core_state),
    .cnt        (core_cnt),
    .done       (core_done),
    .ref_fall   (ref_fall),
    .count_o    (count_o),
    .ready_o    (ready_o)
);

// File: tb/clk_freq_meter_tb.sv
`timescale 1ns/1ps
module clk_freq_meter_tb;

    logic        mclk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        mclk_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        meas_en = 1'b0;
    logic        ref_clk = 1'b0;
    logic [15:0] count_o;
    logic        ready_o;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    bit  mon_on = 0;
    bit  ref_run = 0;
    int  half = 4;
    int  ref_ctr = 0;
    int  exp_count = 0;

    always #2 mclk = ~mclk;     // 250 MHz measured clock
    always #5 rd_clk = ~rd_clk; // reading-domain clock

    clk_freq_meter u_dut (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .meas_en    (meas_en),
        .count_o    (count_o),
        .ready_o    (ready_o),
        .mclk       (mclk),
        .mclk_rst_n (mclk_rst_n),
        .ref_clk    (ref_clk)
    );

    // behavioural reference source: toggles every `half` mclk cycles, away from the edge
    always @(negedge mclk) begin
        if (ref_run) begin
            ref_ctr = ref_ctr + 1;
            if (ref_ctr >= half) begin
                ref_ctr = 0;
                ref_clk = ~ref_clk;
            end
        end
    end

    function automatic int model_count(int h);
        int raw;
        raw = 31 * h;
        return (raw > 65535) ? 65535 : raw;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // per-cycle comparison against the model in the reading domain (R9)
    always @(negedge rd_clk) begin
        if (mon_on && !finished) begin
            if (ready_o) chk(count_o == exp_count[15:0], "R9 ready result", count_o, exp_count);
            else         chk(count_o == 16'd0, "R9 gated zero", count_o, 0);
        end
    end

    task automatic stop_ref();
        @(negedge mclk);
        ref_run = 0;
        ref_clk = 1'b0;
        ref_ctr = 0;
    endtask

    task automatic start_ref(int h);
        @(negedge mclk);
        half = h;
        ref_ctr = 0;
        ref_run = 1;
    endtask

    task automatic wait_ready(int limit, output bit seen);
        seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge rd_clk);
            if (ready_o) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic measure(int h, string req);
        bit seen;
        exp_count = model_count(h);
        @(negedge rd_clk);
        meas_en = 1'b1;
        repeat (40) @(negedge rd_clk);
        chk(!ready_o && count_o == 16'd0, "R1 idle before rise", count_o, 0);
        start_ref(h);
        wait_ready(40000, seen);
        chk(seen, "R3 ready raised", seen, 1);
        chk(count_o == exp_count[15:0], req, count_o, exp_count);
        repeat (6 * h + 10) @(negedge mclk);
        @(negedge rd_clk);
        chk(ready_o && count_o == exp_count[15:0], "R4 frozen", count_o, exp_count);
        stop_ref();
        @(negedge rd_clk);
        meas_en = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk(!ready_o && count_o == 16'd0, "R7 cleared", {ready_o, count_o}, 0);
        repeat (20) @(negedge rd_clk);
    endtask

    initial begin
        bit seen;
        repeat (5) @(negedge rd_clk);
        chk(!ready_o && count_o == 16'd0, "R9 reset state", count_o, 0);
        mclk_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (5) @(negedge rd_clk);
        mon_on = 1;

        measure(3, "R2 count 31*H");
        measure(8, "R5 other rate");
        measure(50, "R8 fresh result");

        // R7: abandon mid-window, then R8: re-enable gives a clean result
        exp_count = model_count(20);
        @(negedge rd_clk);
        meas_en = 1'b1;
        repeat (10) @(negedge rd_clk);
        start_ref(20);
        repeat (150) @(negedge mclk);
        @(negedge rd_clk);
        meas_en = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk(!ready_o && count_o == 16'd0, "R7 abort clears", count_o, 0);
        stop_ref();
        repeat (20) @(negedge rd_clk);
        measure(20, "R8 after abort");

        measure(2200, "R6 saturate");

        // R5: a further rate right after saturation
        measure(5, "R5 fast ratio");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge mclk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule